// File: doc/BRIEF.md
# Accumulator ALU with Status Flag Byte

This block performs one 8-bit arithmetic or logic step on an accumulator value and a second operand. It returns the new result and a complete 8-bit status byte. The operation is picked by a 4-bit code. Additions and subtractions can fold in the incoming carry. Increment and decrement act on the second operand and leave the carry exactly as it came in. The three bitwise operations report parity and force the carry low. Every flag-producing operation copies result bits 3 and 5 into the two otherwise unused status positions.

The arithmetic and the flag assembly are purely combinational. A pair of output registers captures them on any clock edge where the step input is high, so a pipeline can insert the block as a single stage. The asynchronous reset clears both registers at once. Its release is synchronised to the clock, so the registers start loading two rising edges after reset is removed.

Top module: `alu8_flags_top`

## Requirements
- R1: While reset is low, and until the first captured step after it, res_o and flags_o read zero; asserting reset clears them without waiting for a clock edge.
- R2: res_o and flags_o change only at a rising clock edge where step_i is high; with step_i low they hold their value.
- R3: Code 0 (add) gives acc_i + opnd_i and code 1 (add with carry) gives acc_i + opnd_i + flags_i[0]; flag bit 0 takes the carry out of bit 7 and flag bit 1 is cleared.
- R4: Code 2 (subtract) gives acc_i - opnd_i and code 3 (subtract with borrow) gives acc_i - opnd_i - flags_i[0]; flag bit 0 takes the borrow out of bit 7 and flag bit 1 is set.
- R5: For codes 0-3, 7 and 8, flag bit 4 is the carry (for additions) or borrow (for subtractions) between bit 3 and bit 4.
- R6: For codes 0-3, 7 and 8, flag bit 2 is set exactly when the signed two's-complement result lies outside -128..+127.
- R7: Codes 4 (AND), 5 (OR) and 6 (XOR) combine acc_i and opnd_i bitwise. They clear flag bits 0 and 1, set flag bit 2 when the result has an even number of ones, and set flag bit 4 for AND only.
- R8: Code 7 gives opnd_i + 1 and code 8 gives opnd_i - 1, with flag bit 1 cleared for 7 and set for 8. Flag bit 0 keeps the value of flags_i[0].
- R9: For codes 0-8, flag bit 6 is set exactly when the result is zero and flag bit 7 equals result bit 7.
- R10: For codes 0-8, flag bits 3 and 5 equal result bits 3 and 5.
- R11: Codes 9 to 15 return acc_i as the result and flags_i unchanged as the flag byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Capture enable for the output registers |
| op_i | input | 4 | Operation code |
| acc_i | input | DATA_W | Accumulator operand |
| opnd_i | input | DATA_W | Second operand (the target of increment and decrement) |
| flags_i | input | 8 | Incoming flag byte; bit 0 is the carry |
| res_o | output | DATA_W | Registered result |
| flags_o | output | 8 | Registered flag byte |

## Verification
The bench builds the block with DATA_W at its default of 8. That is the width at which the flag byte positions and the -128..+127 overflow limits apply. At this width every operand value, including the 0x7F/0x80 overflow boundaries and the 0xFF/0x00 wrap points, can be reached by the directed vectors. A long pseudo-random sweep over all sixteen operation codes then exercises the carry-in, half-carry and parity paths against a model built from the requirements.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    ALU_ADD = 4'd0,
    ALU_ADC = 4'd1,
    ALU_SUB = 4'd2,
    ALU_SBC = 4'd3,
    ALU_AND = 4'd4,
    ALU_OR  = 4'd5,
    ALU_XOR = 4'd6,
    ALU_INC = 4'd7,
    ALU_DEC = 4'd8
  } alu_op_e;

  localparam logic [3:0] OP_LAST = 4'd8;

  localparam int FLAG_W = 8;
  localparam int FB_C   = 0;
  localparam int FB_N   = 1;
  localparam int FB_PV  = 2;
  localparam int FB_X3  = 3;
  localparam int FB_H   = 4;
  localparam int FB_X5  = 5;
  localparam int FB_Z   = 6;
  localparam int FB_S   = 7;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              half_o,
  output logic              ovf_o
);
  localparam int MSB = DATA_W - 1;
  localparam int NIB = 4;

  logic [DATA_W:0]   ext_a;
  logic [DATA_W:0]   ext_b;
  logic [DATA_W:0]   ext_c;
  logic [DATA_W:0]   wide;
  logic [DATA_W-1:0] mix;
  logic              same_sign;
  logic              res_flip;

  always_comb begin
    ext_a = {1'b0, a_i};
    ext_b = {1'b0, b_i};
    ext_c = {{DATA_W{1'b0}}, cin_i};
    if (sub_i) wide = ext_a - ext_b - ext_c;
    else       wide = ext_a + ext_b + ext_c;
  end

  assign sum_o  = wide[MSB:0];
  assign cout_o = wide[DATA_W];

  // carry or borrow entering bit 4 shows up as a mismatch of the plain xor
  assign mix    = a_i ^ b_i ^ wide[MSB:0];
  assign half_o = mix[NIB];

  assign same_sign = ~(a_i[MSB] ^ b_i[MSB]);
  assign res_flip  = wide[MSB] ^ a_i[MSB];
  assign ovf_o     = sub_i ? (~same_sign & res_flip) : (same_sign & res_flip);

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              half_o
);
  always_comb begin
    res_o  = '0;
    half_o = 1'b0;
    case (op_i)
      ALU_AND: begin
        res_o  = a_i & b_i;
        half_o = 1'b1;
      end
      ALU_OR:  res_o = a_i | b_i;
      ALU_XOR: res_o = a_i ^ b_i;
      default: begin
        res_o  = '0;
        half_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [DATA_W-1:0] res_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  alu_op_e           op;
  logic              known;
  logic              is_logic;
  logic              is_step;
  logic              do_sub;
  logic              use_cin;
  logic [DATA_W-1:0] as_a;
  logic [DATA_W-1:0] as_b;
  logic              as_cin;
  logic [DATA_W-1:0] as_sum;
  logic              as_cout;
  logic              as_half;
  logic              as_ovf;
  logic [DATA_W-1:0] lg_res;
  logic              lg_half;
  logic [DATA_W-1:0] pick;

  always_comb begin
    op       = alu_op_e'(op_i);
    known    = (op_i <= OP_LAST);
    is_logic = (op == ALU_AND) || (op == ALU_OR) || (op == ALU_XOR);
    is_step  = (op == ALU_INC) || (op == ALU_DEC);
    do_sub   = (op == ALU_SUB) || (op == ALU_SBC) || (op == ALU_DEC);
    use_cin  = (op == ALU_ADC) || (op == ALU_SBC);
    as_a     = is_step ? opnd_i : acc_i;
    as_b     = is_step ? ONE : opnd_i;
    as_cin   = use_cin & flags_i[FB_C];
  end

  alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i    (as_a),
    .b_i    (as_b),
    .cin_i  (as_cin),
    .sub_i  (do_sub),
    .sum_o  (as_sum),
    .cout_o (as_cout),
    .half_o (as_half),
    .ovf_o  (as_ovf)
  );

  alu8_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i   (op),
    .a_i    (acc_i),
    .b_i    (opnd_i),
    .res_o  (lg_res),
    .half_o (lg_half)
  );

  always_comb begin
    pick = is_logic ? lg_res : as_sum;
    if (!known) begin
      res_o   = acc_i;
      flags_o = flags_i;
    end else begin
      res_o          = pick;
      flags_o[FB_C]  = is_logic ? 1'b0 : (is_step ? flags_i[FB_C] : as_cout);
      flags_o[FB_N]  = do_sub;
      flags_o[FB_PV] = is_logic ? ~^pick : as_ovf;
      flags_o[FB_X3] = pick[3];
      flags_o[FB_H]  = is_logic ? lg_half : as_half;
      flags_o[FB_X5] = pick[5];
      flags_o[FB_Z]  = (pick == '0);
      flags_o[FB_S]  = pick[MSB];
    end
  end

endmodule

// File: rtl/alu8_flags_top.sv
module alu8_flags_top
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [DATA_W-1:0] res_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;
  logic [DATA_W-1:0]      core_res;
  logic [FLAG_W-1:0]      core_flags;
  logic [DATA_W-1:0]      res_d;
  logic [DATA_W-1:0]      res_q;
  logic [FLAG_W-1:0]      flags_d;
  logic [FLAG_W-1:0]      flags_q;

  // reset asserts at once, releases after SYNC_STAGES rising edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  alu8_core #(.DATA_W(DATA_W)) u_core (
    .op_i    (op_i),
    .acc_i   (acc_i),
    .opnd_i  (opnd_i),
    .flags_i (flags_i),
    .res_o   (core_res),
    .flags_o (core_flags)
  );

  always_comb begin
    res_d   = res_q;
    flags_d = flags_q;
    if (step_i) begin
      res_d   = core_res;
      flags_d = core_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_q   <= '0;
      flags_q <= '0;
    end else begin
      res_q   <= res_d;
      flags_q <= flags_d;
    end
  end

  assign res_o   = res_q;
  assign flags_o = flags_q;

endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_i,
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] acc_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic [DATA_W-1:0] res_o,
  input logic [FLAG_W-1:0] flags_o
);
  localparam int MSB = DATA_W - 1;

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> ($stable(res_o) && $stable(flags_o)));

  // R4
  sub_sets_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && (op_i == ALU_SUB || op_i == ALU_SBC)) |=> flags_o[FB_N]);

  // R7
  logic_clears_cn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && (op_i == ALU_AND || op_i == ALU_OR || op_i == ALU_XOR))
      |=> (!flags_o[FB_C] && !flags_o[FB_N]));

  // R8
  step_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && (op_i == ALU_INC || op_i == ALU_DEC))
      |=> (flags_o[FB_C] == $past(flags_i[FB_C])));

  // R9
  zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && op_i <= OP_LAST)
      |=> ((flags_o[FB_Z] == (res_o == '0)) && (flags_o[FB_S] == res_o[MSB])));

  // R10
  copy_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && op_i <= OP_LAST)
      |=> ((flags_o[FB_X3] == res_o[3]) && (flags_o[FB_X5] == res_o[5])));

  // R11
  unused_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && op_i > OP_LAST)
      |=> ((res_o == $past(acc_i)) && (flags_o == $past(flags_i))));

endmodule

bind alu8_flags_top alu8_flags_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .step_i  (step_i),
  .op_i    (op_i),
  .acc_i   (acc_i),
  .flags_i (flags_i),
  .res_o   (res_o),
  .flags_o (flags_o)
);

// File: tb/sim_alu8_flags_top.sv
`timescale 1ns/1ps
module sim_alu8_flags_top;

  logic       clk;
  logic       rst_n;
  logic       step_i;
  logic [3:0] op_i;
  logic [7:0] acc_i;
  logic [7:0] opnd_i;
  logic [7:0] flags_i;
  logic [7:0] res_o;
  logic [7:0] flags_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  alu8_flags_top #(.DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .op_i(op_i),
    .acc_i(acc_i), .opnd_i(opnd_i), .flags_i(flags_i),
    .res_o(res_o), .flags_o(flags_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {op, acc, opnd, flags_in, exp_res, exp_flags}
  localparam int NV = 18;
  localparam logic [43:0] VEC [NV] = '{
    {4'd0, 8'h0F, 8'h01, 8'h00, 8'h10, 8'h10},
    {4'd0, 8'h7F, 8'h01, 8'h00, 8'h80, 8'h94},
    {4'd0, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h51},
    {4'd1, 8'h10, 8'h20, 8'h01, 8'h31, 8'h20},
    {4'd2, 8'h00, 8'h01, 8'h00, 8'hFF, 8'hBB},
    {4'd2, 8'h80, 8'h01, 8'h00, 8'h7F, 8'h3E},
    {4'd3, 8'h05, 8'h05, 8'h01, 8'hFF, 8'hBB},
    {4'd3, 8'h05, 8'h05, 8'h00, 8'h00, 8'h42},
    {4'd4, 8'hF0, 8'h3C, 8'hFF, 8'h30, 8'h34},
    {4'd5, 8'h01, 8'h02, 8'h00, 8'h03, 8'h04},
    {4'd6, 8'h5A, 8'h5A, 8'hFF, 8'h00, 8'h44},
    {4'd6, 8'h00, 8'h80, 8'h00, 8'h80, 8'h80},
    {4'd7, 8'h11, 8'h7F, 8'h01, 8'h80, 8'h95},
    {4'd8, 8'h22, 8'h80, 8'h00, 8'h7F, 8'h3E},
    {4'd7, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h50},
    {4'd8, 8'h00, 8'h01, 8'h01, 8'h00, 8'h43},
    {4'd9, 8'hA5, 8'h3C, 8'h6B, 8'hA5, 8'h6B},
    {4'd15, 8'h00, 8'h77, 8'h00, 8'h00, 8'h00}
  };

  function automatic int sval(input logic [7:0] v);
    return (v > 8'd127) ? int'(v) - 256 : int'(v);
  endfunction

  // model written from the requirements: returns {res, flags}
  function automatic logic [15:0] model(input logic [3:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic [7:0] f);
    int s, sv, ci, ones;
    logic [7:0] r, fo;
    fo = 8'h00;
    ci = f[0] ? 1 : 0;
    r  = 8'h00;
    case (op)
      4'd0, 4'd1: begin
        if (op == 4'd0) ci = 0;
        s  = int'(a) + int'(b) + ci;
        sv = sval(a) + sval(b) + ci;
        r  = s[7:0];
        fo[0] = (s > 255);
        fo[4] = ((int'(a & 8'h0F) + int'(b & 8'h0F) + ci) > 15);
        fo[2] = (sv > 127) || (sv < -128);
      end
      4'd2, 4'd3: begin
        if (op == 4'd2) ci = 0;
        s  = int'(a) - int'(b) - ci;
        sv = sval(a) - sval(b) - ci;
        r  = s[7:0];
        fo[0] = (s < 0);
        fo[4] = ((int'(a & 8'h0F) - int'(b & 8'h0F) - ci) < 0);
        fo[2] = (sv > 127) || (sv < -128);
        fo[1] = 1'b1;
      end
      4'd4, 4'd5, 4'd6: begin
        r = (op == 4'd4) ? (a & b) : (op == 4'd5) ? (a | b) : (a ^ b);
        ones = 0;
        for (int k = 0; k < 8; k++) if (r[k]) ones++;
        fo[2] = (ones % 2 == 0);
        fo[4] = (op == 4'd4);
      end
      4'd7: begin
        r = b + 8'd1;
        fo[4] = (b[3:0] == 4'hF);
        fo[2] = (b == 8'h7F);
        fo[0] = f[0];
      end
      4'd8: begin
        r = b - 8'd1;
        fo[4] = (b[3:0] == 4'h0);
        fo[2] = (b == 8'h80);
        fo[1] = 1'b1;
        fo[0] = f[0];
      end
      default: ;
    endcase
    if (op > 4'd8) return {a, f};
    fo[6] = (r == 8'h00);
    fo[7] = r[7];
    fo[3] = r[3];
    fo[5] = r[5];
    return {r, fo};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic string main_tag(input logic [3:0] op);
    if (op <= 4'd1) return "R3";
    if (op <= 4'd3) return "R4";
    if (op <= 4'd6) return "R7";
    if (op <= 4'd8) return "R8";
    return "R11";
  endfunction

  // outputs compared field by field, each field under its own requirement
  task automatic check_out(input logic [3:0] op, input logic [7:0] er, input logic [7:0] ef);
    string t;
    t = main_tag(op);
    chk({t, " result"}, res_o, er);
    if (op > 4'd8) begin
      chk("R11 flags", flags_o, ef);
    end else begin
      chk({t, " carry/subtract"}, {6'd0, flags_o[1:0]}, {6'd0, ef[1:0]});
      chk((op >= 4'd4 && op <= 4'd6) ? "R7 half" : "R5 half",
          {7'd0, flags_o[4]}, {7'd0, ef[4]});
      chk((op >= 4'd4 && op <= 4'd6) ? "R7 parity" : "R6 overflow",
          {7'd0, flags_o[2]}, {7'd0, ef[2]});
      chk("R9 zero/sign", {6'd0, flags_o[7:6]}, {6'd0, ef[7:6]});
      chk("R10 copy bits", {6'd0, flags_o[5], flags_o[3]}, {6'd0, ef[5], ef[3]});
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] f, input logic st);
    op_i = op; acc_i = a; opnd_i = b; flags_i = f; step_i = st;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] seed;
    logic [15:0] exp;
    logic [7:0]  held_r, held_f;
    rst_n = 1'b0;
    drive(4'd0, 8'h00, 8'h00, 8'h00, 1'b0);
    repeat (3) @(negedge clk);
    chk("R1 reset result", res_o, 8'h00);
    chk("R1 reset flags", flags_o, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release result", res_o, 8'h00);
    chk("R1 after release flags", flags_o, 8'h00);

    // directed vector table
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][43:40], VEC[i][39:32], VEC[i][31:24], VEC[i][23:16], 1'b1);
      @(negedge clk);
      check_out(VEC[i][43:40], VEC[i][15:8], VEC[i][7:0]);
    end

    // R2: step low holds outputs; first load a nonzero value
    drive(4'd0, 8'h12, 8'h34, 8'h00, 1'b1);
    @(negedge clk);
    held_r = res_o;
    held_f = flags_o;
    chk("R3 preload", held_r, 8'h46);
    drive(4'd2, 8'h00, 8'h01, 8'hFF, 1'b0);
    @(negedge clk);
    chk("R2 hold result", res_o, held_r);
    chk("R2 hold flags", flags_o, held_f);
    drive(4'd9, 8'hEE, 8'h00, 8'h5A, 1'b0);
    @(negedge clk);
    chk("R2 hold result again", res_o, held_r);
    chk("R2 hold flags again", flags_o, held_f);

    // pseudo-random sweep over every code
    seed = 32'h1357_9BDF;
    for (int n = 0; n < 4000; n++) begin
      seed ^= seed << 13;
      seed ^= seed >> 17;
      seed ^= seed << 5;
      drive(seed[3:0], seed[11:4], seed[19:12], seed[27:20], 1'b1);
      exp = model(seed[3:0], seed[11:4], seed[19:12], seed[27:20]);
      @(negedge clk);
      check_out(seed[3:0], exp[15:8], exp[7:0]);
    end

    // R1: reset mid-run clears outputs without a clock edge
    drive(4'd0, 8'hF0, 8'h0F, 8'h00, 1'b1);
    @(negedge clk);
    chk("R3 before reset", res_o, 8'hFF);
    step_i = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    chk("R1 async clear result", res_o, 8'h00);
    chk("R1 async clear flags", flags_o, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after second release", res_o, 8'h00);

    finish_run();
  end

endmodule